// File: doc/BRIEF.md
# Banked Memory and IO Port Decoder

This block sits between the CPU bus of an 8-bit home computer with 128 KB of banked RAM and two external memories: a 16-bit wide SRAM and an 8-bit flash that holds the system ROM images. It splits the 64 KB CPU space into four 16 KB windows. The lowest window reads a ROM page from flash. The two middle windows always reach two fixed RAM banks. The top window reaches whichever of eight RAM banks software has chosen. For each access it produces a chip select, a write enable and a physical address.

Two IO registers are decoded from single address bits, not from full port numbers. The first is a write-only paging register. It picks the top-window bank, the ROM page and an alternate screen bank, and it can lock itself until reset. The second is a latch on every even IO address. It holds the border colour, the beeper bit and the tape-output bit. Both registers take data on the clock edge that samples the IO write. The address mapping itself is combinational.

Top module: `mem_page_decoder`

## Requirements
- R1: A memory read with cpu_addr[15:14]=00 asserts rom_cs and no RAM select. rom_addr equals ROM_BASE (default 0x08000) + rom_page*0x4000 + cpu_addr[13:0], where rom_page is paging bit 4.
- R2: A memory write with cpu_addr[15:14]=00 asserts neither rom_cs nor ram_cs.
- R3: Window 01 (0x4000-0x7FFF) always maps to RAM bank 5, and window 10 (0x8000-0xBFFF) always maps to RAM bank 2, whatever the paging register holds.
- R4: Window 11 (0xC000-0xFFFF) maps to the RAM bank in paging bits 2:0. The RAM byte address is {bank, cpu_addr[13:0]}. ram_addr is that byte address shifted right by one (a 16-bit word), and ram_upper equals cpu_addr[0] (1 = upper byte lane).
- R5: A memory read or write in windows 01 to 11 asserts ram_cs, and ram_we is high only for writes.
- R6: The paging register loads cpu_din[5:0] only on an IO write with cpu_addr[0]=1, cpu_addr[1]=0 and cpu_addr[15]=0. The following leave it unchanged: other IO addresses, IO reads and memory cycles.
- R7: Once paging bit 5 is written as 1, every further paging write is ignored until reset.
- R8: An IO write to any address with cpu_addr[0]=0 loads border from cpu_din[2:0], tape_out from cpu_din[3] and beeper from cpu_din[4]. IO writes to odd addresses leave these outputs unchanged.
- R9: Reset clears the paging register, the lock and the port latch. This gives bank 0, ROM page 0, border 0, beeper 0, tape_out 0 and scr_alt 0.
- R10: scr_alt follows paging bit 3.
- R11: Register outputs change at the clock edge that samples the IO write. The memory mapping outputs follow the bus inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | Data driven by the CPU |
| mem_req | input | 1 | Memory cycle strobe, active high |
| io_req | input | 1 | IO cycle strobe, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| ram_addr | output | 16 | SRAM word address |
| ram_upper | output | 1 | Selects the upper SRAM byte lane |
| ram_cs | output | 1 | SRAM select |
| ram_we | output | 1 | SRAM write enable |
| rom_addr | output | 22 | Flash byte address |
| rom_cs | output | 1 | Flash read select |
| border | output | 3 | Latched border colour |
| beeper | output | 1 | Latched beeper bit |
| tape_out | output | 1 | Latched tape output bit |
| scr_alt | output | 1 | Alternate screen bank selected |

## Verification
The mapping outputs are combinational, so they are due in the same cycle as the bus inputs. The bench sets each memory cycle just after a falling edge and samples a quarter period later, before the next rising edge. The paging register and the port latch are due one rising edge after the IO write is presented. The bench holds each IO write across exactly one rising edge, drops it at the next falling edge, and only then reads the latched outputs or probes the top window. This way an ignored write can be seen to have changed nothing before the next stimulus arrives.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
   localparam int CPU_AW   = 16;
   localparam int WIN_AW   = 14;
   localparam int N_WIN    = 1 << (CPU_AW - WIN_AW);

   // Paging register field positions (software-visible encoding)
   localparam int PG_BANK_LSB = 0;
   localparam int PG_SCR_BIT  = 3;
   localparam int PG_ROM_BIT  = 4;
   localparam int PG_LOCK_BIT = 5;
   localparam int PG_W        = 6;

   // Port latch field positions
   localparam int UL_BORDER_LSB = 0;
   localparam int UL_TAPE_BIT   = 3;
   localparam int UL_BEEP_BIT   = 4;
   localparam int UL_W          = 5;

   typedef struct packed {
      logic [2:0] border;
      logic       tape;
      logic       beep;
   } port_latch_t;

   typedef enum logic [1:0] {
      WIN_ROM  = 2'd0,
      WIN_LOW  = 2'd1,
      WIN_HIGH = 2'd2,
      WIN_PAGE = 2'd3
   } win_e;
endpackage

// File: rtl/mpd_io_decode.sv
module mpd_io_decode (
   input  logic        io_req,
   input  logic        wr,
   input  logic [15:0] addr,
   output logic        latch_wr,
   output logic        page_wr
);
   logic io_write;
   logic a_unused;

   assign io_write = io_req & wr;
   // Even addresses reach the port latch
   assign latch_wr = io_write & ~addr[0];
   // Odd, A1 low, A15 low reach the paging register
   assign page_wr  = io_write & addr[0] & ~addr[1] & ~addr[15];
   assign a_unused = ^addr[14:2];
endmodule

// File: rtl/mpd_page_reg.sv
module mpd_page_reg #(
   parameter int BANK_W = 3,
   parameter int ROM_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_wr,
   input  logic [5:0]        din,
   output logic [BANK_W-1:0] bank,
   output logic [ROM_W-1:0]  rom_page,
   output logic              scr_alt,
   output logic              locked
);
   import mpd_pkg::*;

   logic [PG_W-1:0] pg_q;
   logic            load;

   assign load = page_wr & ~pg_q[PG_LOCK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pg_q <= '0;
      else if (load)
         pg_q <= din;
   end

   assign bank    = pg_q[PG_BANK_LSB +: BANK_W];
   assign scr_alt = pg_q[PG_SCR_BIT];
   assign locked  = pg_q[PG_LOCK_BIT];

   generate
      if (ROM_W == 1) begin : g_rom1
         assign rom_page = pg_q[PG_ROM_BIT];
      end else begin : g_romn
         assign rom_page = ROM_W'(pg_q[PG_ROM_BIT]);
      end
   endgenerate
endmodule

// File: rtl/mpd_port_latch.sv
module mpd_port_latch (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        latch_wr,
   input  logic [4:0]  din,
   output mpd_pkg::port_latch_t q
);
   import mpd_pkg::*;

   port_latch_t nxt;

   always_comb begin
      nxt.border = din[UL_BORDER_LSB +: 3];
      nxt.tape   = din[UL_TAPE_BIT];
      nxt.beep   = din[UL_BEEP_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (latch_wr)
         q <= nxt;
   end
endmodule

// File: rtl/mpd_addr_map.sv
module mpd_addr_map #(
   parameter int BANK_W   = 3,
   parameter int ROM_W    = 1,
   parameter int FLASH_AW = 22,
   parameter logic [FLASH_AW-1:0] ROM_BASE = 22'h008000,
   parameter int FIX_LO   = 5,
   parameter int FIX_HI   = 2,
   localparam int RAM_WAW = BANK_W + mpd_pkg::WIN_AW - 1
) (
   input  logic [15:0]        addr,
   input  logic               mem_req,
   input  logic               rd,
   input  logic               wr,
   input  logic [BANK_W-1:0]  page_bank,
   input  logic [ROM_W-1:0]   rom_page,
   output logic [RAM_WAW-1:0] ram_addr,
   output logic               ram_upper,
   output logic               ram_cs,
   output logic               ram_we,
   output logic [FLASH_AW-1:0] rom_addr,
   output logic               rom_cs
);
   import mpd_pkg::*;

   logic [BANK_W-1:0] win_bank [N_WIN];
   logic [1:0]        win;
   logic              in_rom;
   logic [BANK_W-1:0] bank;

   // One bank source per window; the ROM window carries a dummy zero
   generate
      for (genvar w = 0; w < N_WIN; w++) begin : g_win
         if (w == int'(WIN_ROM)) begin : g_rom
            assign win_bank[w] = '0;
         end else if (w == int'(WIN_LOW)) begin : g_lo
            assign win_bank[w] = BANK_W'(FIX_LO);
         end else if (w == int'(WIN_HIGH)) begin : g_hi
            assign win_bank[w] = BANK_W'(FIX_HI);
         end else begin : g_pg
            assign win_bank[w] = page_bank;
         end
      end
   endgenerate

   assign win    = addr[15:14];
   assign in_rom = (win == WIN_ROM);
   assign bank   = win_bank[win];

   assign ram_addr  = {bank, addr[WIN_AW-1:1]};
   assign ram_upper = addr[0];
   assign ram_cs    = mem_req & (rd | wr) & ~in_rom;
   assign ram_we    = ram_cs & wr;

   assign rom_addr  = ROM_BASE + FLASH_AW'({rom_page, addr[WIN_AW-1:0]});
   assign rom_cs    = mem_req & rd & ~wr & in_rom;
endmodule

// File: rtl/mem_page_decoder.sv
module mem_page_decoder #(
   parameter int BANK_W   = 3,
   parameter int ROM_W    = 1,
   parameter int FLASH_AW = 22,
   parameter logic [FLASH_AW-1:0] ROM_BASE = 22'h008000,
   parameter int FIX_LO   = 5,
   parameter int FIX_HI   = 2,
   localparam int RAM_WAW = BANK_W + mpd_pkg::WIN_AW - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [15:0]         cpu_addr,
   input  logic [7:0]          cpu_din,
   input  logic                mem_req,
   input  logic                io_req,
   input  logic                rd,
   input  logic                wr,
   output logic [RAM_WAW-1:0]  ram_addr,
   output logic                ram_upper,
   output logic                ram_cs,
   output logic                ram_we,
   output logic [FLASH_AW-1:0] rom_addr,
   output logic                rom_cs,
   output logic [2:0]          border,
   output logic                beeper,
   output logic                tape_out,
   output logic                scr_alt
);
   import mpd_pkg::*;

   generate
      if (BANK_W != 3) begin : g_err_bank
         $error("BANK_W must be 3: the bank field is three paging bits");
      end
      if (ROM_W != 1) begin : g_err_rom
         $error("ROM_W must be 1: one paging bit selects the ROM");
      end
      if (FIX_LO >= (1 << BANK_W) || FIX_HI >= (1 << BANK_W)) begin : g_err_fix
         $error("fixed banks must lie inside the bank range");
      end
      if (FLASH_AW < BANK_W + WIN_AW) begin : g_err_fl
         $error("FLASH_AW too small");
      end
   endgenerate

   logic              latch_wr;
   logic              page_wr;
   logic [BANK_W-1:0] page_bank;
   logic [ROM_W-1:0]  rom_page;
   logic              page_locked;
   port_latch_t       pl_q;
   logic              din_unused;

   assign din_unused = ^cpu_din[7:6];

   mpd_io_decode u_dec (
      .io_req   (io_req),
      .wr       (wr),
      .addr     (cpu_addr),
      .latch_wr (latch_wr),
      .page_wr  (page_wr)
   );

   mpd_page_reg #(.BANK_W(BANK_W), .ROM_W(ROM_W)) u_page (
      .clk      (clk),
      .rst_n    (rst_n),
      .page_wr  (page_wr),
      .din      (cpu_din[5:0]),
      .bank     (page_bank),
      .rom_page (rom_page),
      .scr_alt  (scr_alt),
      .locked   (page_locked)
   );

   mpd_port_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .latch_wr (latch_wr),
      .din      (cpu_din[4:0]),
      .q        (pl_q)
   );

   mpd_addr_map #(
      .BANK_W(BANK_W), .ROM_W(ROM_W), .FLASH_AW(FLASH_AW),
      .ROM_BASE(ROM_BASE), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)
   ) u_map (
      .addr      (cpu_addr),
      .mem_req   (mem_req),
      .rd        (rd),
      .wr        (wr),
      .page_bank (page_bank),
      .rom_page  (rom_page),
      .ram_addr  (ram_addr),
      .ram_upper (ram_upper),
      .ram_cs    (ram_cs),
      .ram_we    (ram_we),
      .rom_addr  (rom_addr),
      .rom_cs    (rom_cs)
   );

   assign border   = pl_q.border;
   assign tape_out = pl_q.tape;
   assign beeper   = pl_q.beep;
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker #(
   parameter int BANK_W  = 3,
   parameter int FIX_LO  = 5,
   parameter int FIX_HI  = 2,
   parameter int RAM_WAW = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [15:0]        cpu_addr,
   input logic               mem_req,
   input logic               io_req,
   input logic               wr,
   input logic [RAM_WAW-1:0] ram_addr,
   input logic               ram_cs,
   input logic               rom_cs,
   input logic [2:0]         border,
   input logic               beeper,
   input logic               tape_out,
   input logic [BANK_W-1:0]  page_bank,
   input logic               page_locked
);
   logic even_io_wr;
   logic page_io_wr;

   assign even_io_wr = io_req && wr && !cpu_addr[0];
   assign page_io_wr = io_req && wr && cpu_addr[0] && !cpu_addr[1] && !cpu_addr[15];

   a_r1_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_cs && ram_cs));

   a_r2_rom_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && wr && cpu_addr[15:14] == 2'b00) |-> (!rom_cs && !ram_cs));

   a_r3_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_cs && cpu_addr[15:14] == 2'b01) |-> ram_addr[RAM_WAW-1 -: BANK_W] == BANK_W'(FIX_LO));

   a_r3_fixed_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_cs && cpu_addr[15:14] == 2'b10) |-> ram_addr[RAM_WAW-1 -: BANK_W] == BANK_W'(FIX_HI));

   a_r6_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !page_io_wr |=> $stable(page_bank));

   a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      page_locked |=> ($stable(page_bank) && page_locked));

   a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !even_io_wr |=> ($stable(border) && $stable(beeper) && $stable(tape_out)));
endmodule

bind mem_page_decoder mpd_checker #(
   .BANK_W(BANK_W), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI), .RAM_WAW(RAM_WAW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_addr    (cpu_addr),
   .mem_req     (mem_req),
   .io_req      (io_req),
   .wr          (wr),
   .ram_addr    (ram_addr),
   .ram_cs      (ram_cs),
   .rom_cs      (rom_cs),
   .border      (border),
   .beeper      (beeper),
   .tape_out    (tape_out),
   .page_bank   (page_bank),
   .page_locked (page_locked)
);

// File: tb/mem_page_decoder_tb_top.sv
module mem_page_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_din = '0;
   logic        mem_req = 1'b0;
   logic        io_req = 1'b0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] ram_addr;
   logic        ram_upper;
   logic        ram_cs;
   logic        ram_we;
   logic [21:0] rom_addr;
   logic        rom_cs;
   logic [2:0]  border;
   logic        beeper;
   logic        tape_out;
   logic        scr_alt;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   mem_page_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
      .mem_req(mem_req), .io_req(io_req), .rd(rd), .wr(wr),
      .ram_addr(ram_addr), .ram_upper(ram_upper), .ram_cs(ram_cs), .ram_we(ram_we),
      .rom_addr(rom_addr), .rom_cs(rom_cs), .border(border), .beeper(beeper),
      .tape_out(tape_out), .scr_alt(scr_alt)
   );

   // {page value, cpu address, is_rom, expected physical address}
   localparam int NV = 10;
   localparam logic [63:0] VEC [NV] = '{
      {8'h00, 16'h0123, 8'h01, 32'h0000_8123},
      {8'h10, 16'h3FFF, 8'h01, 32'h0000_FFFF},
      {8'h00, 16'h4000, 8'h00, 32'h0000_A000},
      {8'h07, 16'h7FFE, 8'h00, 32'h0000_BFFF},
      {8'h03, 16'h8001, 8'h00, 32'h0000_4000},
      {8'h03, 16'hC000, 8'h00, 32'h0000_6000},
      {8'h07, 16'hFFFF, 8'h00, 32'h0000_FFFF},
      {8'h01, 16'hC456, 8'h00, 32'h0000_222B},
      {8'h0D, 16'hE000, 8'h00, 32'h0000_B000},
      {8'h16, 16'h0000, 8'h01, 32'h0000_C000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      mem_req = 0; io_req = 0; rd = 0; wr = 0;
   endtask

   // Held across one rising edge; the register is visible after it
   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_din = d; io_req = 1; wr = 1; rd = 0; mem_req = 0;
      @(negedge clk);
      io_req = 0; wr = 0;
      #2;
   endtask

   task automatic io_read(input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a; cpu_din = 8'h3F; io_req = 1; rd = 1; wr = 0;
      @(negedge clk);
      io_req = 0; rd = 0;
      #2;
   endtask

   // Combinational result sampled a quarter period after driving
   task automatic mem_cycle(input logic [15:0] a, input logic w, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_din = d; mem_req = 1; rd = ~w; wr = w; io_req = 0;
      #5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      mem_req = 0; io_req = 0; rd = 0; wr = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      #2;
   endtask

   task automatic top_bank(input string req, input logic [2:0] exp_bank);
      mem_cycle(16'hC000, 1'b0, 8'h00);
      check(req, {16'h0, ram_addr}, {16'h0, exp_bank, 13'h0});
      idle();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      do_reset();

      // R9: reset state of latched outputs
      check("R9 border", {29'h0, border}, 32'h0);
      check("R9 beeper/tape/scr", {29'h0, beeper, tape_out, scr_alt}, 32'h0);
      top_bank("R9 bank0 after reset", 3'd0);
      mem_cycle(16'h0000, 1'b0, 8'h00);
      check("R9 rom page 0", {10'h0, rom_addr}, 32'h0000_8000);
      idle();

      // Table: R1 R3 R4 mapping under several paging values
      for (int i = 0; i < NV; i++) begin
         io_write(16'h7FFD, VEC[i][63:56]);
         mem_cycle(VEC[i][55:40], 1'b0, 8'h00);
         if (VEC[i][32]) begin
            check("R1 rom_cs", {31'h0, rom_cs}, 32'h1);
            check("R1 rom_addr", {10'h0, rom_addr}, VEC[i][31:0]);
            check("R1 ram_cs low", {31'h0, ram_cs}, 32'h0);
         end else begin
            check("R5 ram_cs", {30'h0, ram_cs, ram_we}, 32'h2);
            check("R4 R3 ram_addr", {16'h0, ram_addr}, VEC[i][31:0]);
            check("R4 ram_upper", {31'h0, ram_upper}, {31'h0, VEC[i][40]});
            check("R1 rom_cs low", {31'h0, rom_cs}, 32'h0);
         end
         idle();
      end

      // R10: screen bank bit from the last table entry (0x16 -> bit3 clear)
      check("R10 scr_alt clear", {31'h0, scr_alt}, 32'h0);
      io_write(16'h7FFD, 8'h08);
      check("R10 scr_alt set", {31'h0, scr_alt}, 32'h1);

      // R8 / R11: port latch on even addresses, visible after the edge
      io_write(16'h00FE, 8'h1D);
      check("R8 R11 border", {29'h0, border}, 32'h5);
      check("R8 tape", {31'h0, tape_out}, 32'h1);
      check("R8 beeper", {31'h0, beeper}, 32'h1);
      io_write(16'h1234, 8'h02);
      check("R8 alias border", {29'h0, border, beeper, tape_out}, {27'h0, 3'd2, 2'b00});
      io_write(16'h00FF, 8'h07);
      check("R8 odd ignored", {29'h0, border}, 32'h2);
      top_bank("R6 0x00FF misses page reg", 3'd0);

      // R6: partial decoding of the paging register
      io_write(16'h0001, 8'h04);
      top_bank("R6 alias 0x0001", 3'd4);
      io_write(16'hFFFD, 8'h06);
      top_bank("R6 A15 high ignored", 3'd4);
      io_write(16'h7FFF, 8'h06);
      top_bank("R6 A1 high ignored", 3'd4);
      io_read(16'h7FFD);
      top_bank("R6 IO read ignored", 3'd4);

      // R5 / R6: memory write to the port address
      mem_cycle(16'h7FFD, 1'b1, 8'h07);
      check("R5 ram write", {30'h0, ram_cs, ram_we}, 32'h3);
      idle();
      top_bank("R6 memory write ignored", 3'd4);

      // R2: writes into the ROM window reach no memory
      mem_cycle(16'h0010, 1'b1, 8'hAA);
      check("R2 no select", {30'h0, rom_cs, ram_cs}, 32'h0);
      idle();

      // R7: lock
      io_write(16'h7FFD, 8'h21);
      top_bank("R7 locking write lands", 3'd1);
      io_write(16'h7FFD, 8'h07);
      top_bank("R7 locked write ignored", 3'd1);
      io_write(16'h7FFD, 8'h10);
      mem_cycle(16'h0000, 1'b0, 8'h00);
      check("R7 rom page held", {10'h0, rom_addr}, 32'h0000_8000);
      idle();

      // R9: reset clears the lock and the latch
      do_reset();
      check("R9 latch cleared", {29'h0, border}, 32'h0);
      io_write(16'h7FFD, 8'h03);
      top_bank("R9 lock cleared", 3'd3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule